// File: doc/BRIEF.md
# Grayscale PWM Output Controller

This block produces the on/off enables for a row of constant-current LED sinks. For each of its channels, it compares a latched grayscale word against a shared count of grayscale clock pulses. A channel stays lit from the start of a cycle until the count reaches that channel's word. Brightness therefore scales with the word, and a word of zero keeps the channel dark. A mode input chooses between a wide count and a narrow count. In the narrow mode only the low half of each word takes part. A divide setting lets the count advance once per several grayscale clocks.

A blanking input darkens every channel at once and clears the count, so each new frame starts from zero. After blanking is released the outputs do not light at once. They wait for a rising grayscale clock edge and then the falling edge after it. This keeps turn-on aligned to the grayscale clock in every device of a chain. Registered copies of the grayscale clock and of the blank signal are provided so that the next device downstream can be driven from this one.

Everything runs on one system clock. The grayscale clock and the blank input are sampled as levels on that clock.

Top module: `gs_pwm_ctrl`

## Requirements
- R1: While running, channel i is on exactly when its effective word is greater than the grayscale count; the word for channel i sits at gs_data[i*16 +: 16], and the count starts at 0 and advances on sampled rising edges of gs_clk.
- R2: While blank is high, every ch_on bit is 0 in the same cycle, and the count, the divider phase and the run state are cleared on each clock edge that samples blank high.
- R3: After blank falls, outputs stay off until a sampled rising edge of gs_clk and then a sampled falling edge; the outputs take effect after the clock edge that samples that falling edge, and that rising edge is not counted.
- R4: With mode_wide = 1 the full 16-bit word and a 16-bit count are used; with mode_wide = 0 only bits [7:0] of each word are used and the count's full scale is 255.
- R5: When the count reaches full scale it holds there until blank is asserted and never wraps to zero.
- R6: The count advances once every div_sel+1 sampled rising edges of gs_clk; div_sel = 0 gives a ratio of 1/1.
- R7: gs_clk_buf and blank_buf repeat gs_clk and blank one clock cycle later.
- R8: A channel whose effective word is 0 never turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gs_clk | input | 1 | Grayscale clock level, sampled on clk |
| blank | input | 1 | High darkens all outputs and clears the count |
| mode_wide | input | 1 | 1 selects 16-bit counting, 0 selects 8-bit counting |
| div_sel | input | 4 | Grayscale clock divide setting; ratio is 1/(div_sel+1) |
| gs_data | input | 256 | Packed grayscale words, channel i at [i*16 +: 16] |
| ch_on | output | 16 | Per-channel sink enables |
| gs_clk_buf | output | 1 | gs_clk delayed by one clk cycle |
| blank_buf | output | 1 | blank delayed by one clk cycle |

## Verification
The bench drives each input change on a falling clk edge. A gs_clk edge is seen by the next rising clk edge. The count or run state it changes is visible on ch_on right after that edge, because the outputs are decoded from registers and the words without a further register. Each grayscale period is held for four clk cycles, and checks sample at the falling clk edge that closes the period. By then the period's rising edge and falling edge have both been registered. Blanking is checked one nanosecond after it is driven, since its effect on ch_on needs no clock. The buffered outputs are checked one clk cycle after the input moves.

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl #(
  parameter int CH   = 16,
  parameter int GSW  = 16,
  parameter int DIVW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gs_clk,
  input  logic              blank,
  input  logic              mode_wide,
  input  logic [DIVW-1:0]   div_sel,
  input  logic [CH*GSW-1:0] gs_data,
  output logic [CH-1:0]     ch_on,
  output logic              gs_clk_buf,
  output logic              blank_buf
);
  localparam int NW = GSW / 2;

  logic            gs_q, armed, run;
  logic [GSW-1:0]  cnt, full;
  logic [DIVW-1:0] pre;
  logic            rise, fall;

  assign rise       = gs_clk & ~gs_q;
  assign fall       = ~gs_clk & gs_q;
  assign full       = mode_wide ? {GSW{1'b1}} : {{(GSW-NW){1'b0}}, {NW{1'b1}}};
  assign gs_clk_buf = gs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_q      <= 1'b0;
      blank_buf <= 1'b1;
      armed     <= 1'b0;
      run       <= 1'b0;
      cnt       <= '0;
      pre       <= '0;
    end else begin
      gs_q      <= gs_clk;
      blank_buf <= blank;
      if (blank) begin
        armed <= 1'b0;
        run   <= 1'b0;
        cnt   <= '0;
        pre   <= '0;
      end else begin
        if (!run && rise) armed <= 1'b1;
        if (!run && armed && fall) run <= 1'b1;
        if (run && rise) begin
          if (pre == div_sel) begin
            pre <= '0;
            if (cnt < full) cnt <= cnt + 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [GSW-1:0] word, eff;
    assign word     = gs_data[i*GSW +: GSW];
    assign eff      = mode_wide ? word : {{(GSW-NW){1'b0}}, word[NW-1:0]};
    assign ch_on[i] = run & ~blank & (eff > cnt);
  end

  a_r2_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blank) |-> (cnt == '0 && !run && pre == '0));

  a_r3_turn_on_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!$past(gs_clk) && $past(gs_q)));

  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && cnt >= full) |=> cnt == $past(cnt));

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));

  a_r7_buf_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (gs_clk_buf == $past(gs_clk) && blank_buf == $past(blank)));

  a_r2_dark_when_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> ch_on == '0);
endmodule

// File: tb/gs_pwm_ctrl_tb.sv
module gs_pwm_ctrl_tb_top;
  localparam int CH = 16;
  localparam int GSW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              gs_clk = 1'b0;
  logic              blank = 1'b1;
  logic              mode_wide = 1'b0;
  logic [3:0]        div_sel = '0;
  logic [CH*GSW-1:0] gs_data = '0;
  logic [CH-1:0]     ch_on;
  logic              gs_clk_buf, blank_buf;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] vals [CH];

  always #10 clk = ~clk;

  gs_pwm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .gs_clk(gs_clk), .blank(blank),
    .mode_wide(mode_wide), .div_sel(div_sel), .gs_data(gs_data),
    .ch_on(ch_on), .gs_clk_buf(gs_clk_buf), .blank_buf(blank_buf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CH-1:0] expect_on(input int rises, input bit running);
    logic [CH-1:0] r;
    int c, fs, v;
    fs = mode_wide ? 65535 : 255;
    c = rises / (int'(div_sel) + 1);
    if (c > fs) c = fs;
    for (int i = 0; i < CH; i++) begin
      v = mode_wide ? int'(vals[i]) : int'(vals[i][7:0]);
      r[i] = running && (v > c);
    end
    return r;
  endfunction

  task automatic load_vals();
    for (int i = 0; i < CH; i++) gs_data[i*GSW +: GSW] = vals[i];
  endtask

  task automatic gs_period(input bit chk_buf);
    gs_clk = 1'b1;
    @(negedge clk);
    if (chk_buf) check("R7 gs_clk_buf high", gs_clk_buf, 1);
    @(negedge clk);
    gs_clk = 1'b0;
    @(negedge clk);
    if (chk_buf) check("R7 gs_clk_buf low", gs_clk_buf, 0);
    @(negedge clk);
  endtask

  task automatic start_frame();
    blank = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 dark while blank", ch_on, 0);
    check("R7 blank_buf high", blank_buf, 1);
    blank = 1'b0;
    @(negedge clk);
    check("R7 blank_buf low", blank_buf, 0);
    check("R3 off after release", ch_on, 0);
    gs_clk = 1'b1;
    @(negedge clk);
    check("R3 off after rise only", ch_on, 0);
    gs_clk = 1'b0;
    @(negedge clk);
    check("R3 R8 on after fall", ch_on, expect_on(0, 1));
    @(negedge clk);
  endtask

  task automatic run_frame(input int nper, input string req);
    start_frame();
    for (int k = 1; k <= nper; k++) begin
      gs_period(k < 4);
      check(req, ch_on, expect_on(k, 1));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset dark", ch_on, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R8: 8-bit mode, full sweep past saturation
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0007, 16'h000F, 16'h001F, 16'h003F,
             16'h0064, 16'h007F, 16'h0080, 16'h00C8, 16'h00FE, 16'h00FF, 16'h1234, 16'hFF00};
    load_vals();
    mode_wide = 1'b0;
    div_sel = 4'd0;
    run_frame(262, "R1 R4 R5 8-bit sweep");

    // R2: blank mid-frame darkens at once, restart begins at zero
    @(negedge clk);
    blank = 1'b1;
    #1;
    check("R2 immediate dark", ch_on, 0);
    run_frame(4, "R2 restart from zero");

    // R4: 16-bit mode with words above 255
    vals = '{16'h0000, 16'h0001, 16'h0005, 16'h0105, 16'h0100, 16'hFFFF, 16'h00FF, 16'h0101,
             16'h0080, 16'h012C, 16'h0002, 16'h0110, 16'h8000, 16'h00FE, 16'h0003, 16'h0120};
    load_vals();
    mode_wide = 1'b1;
    run_frame(305, "R1 R4 16-bit sweep");

    // R6: divided grayscale clock
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 16'h0006, 16'h0007,
             16'h0008, 16'h0009, 16'h000A, 16'h000B, 16'h000C, 16'h000D, 16'h000E, 16'h000F};
    load_vals();
    mode_wide = 1'b0;
    div_sel = 4'd2;
    run_frame(50, "R6 divide by 3");
    div_sel = 4'd0;
    run_frame(18, "R6 divide by 1");

    // R8: all-zero words stay dark throughout
    for (int i = 0; i < CH; i++) vals[i] = 16'h0000;
    load_vals();
    run_frame(6, "R8 zero words dark");

    summary();
  end
endmodule